// File: doc/BRIEF.md
# Receive Loss-of-Signal Detector

This block watches the recovered receive bit stream of a line interface, one bit per cycle in which the bit strobe is high. A bit counts as a mark when either rail detected a pulse. All other bits count as zeros. After a long unbroken run of zeros it raises a loss-of-signal flag. While the flag is high, only a proven return of traffic lowers it again. That proof is an observation window that opens on a received mark, lasts a fixed number of bits, carries enough marks, and never sees an excessively long zero run.

A count of the current zero run is brought out for debug. An optional all-ones indication is also provided. It is judged over free-running frames of the same length as the recovery window. It shows an unframed all-ones (alarm indication) signal.

Top module: `lossig_detector`

## Requirements
- R1: After reset `los` is 0, `zero_run` is 0 and `ais` is 0.
- R2: On each strobed bit, `zero_run` returns to 0 when `mark` is 1. When `mark` is 0 it increments, saturating at 255 with the default parameters.
- R3: With `los` low, the strobed zero that completes a run of 175 consecutive zeros sets `los`. The flag is visible from the same clock edge that registers that bit. A run of 174 zeros leaves `los` low.
- R4: While `los` is high, a recovery window opens only on a strobed mark. Zeros received before that mark neither open a window nor lower `los`.
- R5: `los` clears on the edge that registers the 175th bit of an open window, counting the opening mark as bit 1. This happens when the window holds at least 22 marks and no run of 100 or more zeros. A window whose longest zero run is 99 still passes.
- R6: A window in which 100 consecutive zeros occur is abandoned at the 100th zero and `los` stays high. The next strobed mark opens a fresh window.
- R7: A window that reaches 175 bits with 21 or fewer marks leaves `los` high. The next strobed mark opens a fresh window.
- R8: Bits are grouped from reset into back-to-back frames of 175 strobed bits. At the end of each frame, `ais` is set when the frame held fewer than 3 zeros and is cleared otherwise. Between frame ends, `ais` holds.
- R9: In a cycle with `bit_en` low, the value of `mark` has no effect. `los`, `zero_run`, `ais` and all window progress stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: one received bit is presented this cycle |
| mark | input | 1 | Received bit is a mark (either rail detected a pulse) |
| los | output | 1 | Loss-of-signal flag |
| zero_run | output | 8 | Consecutive zeros received, saturating |
| ais | output | 1 | All-ones indication from the last completed frame |

## Verification
A corrupted zero-run counter shows directly on `zero_run` at the next strobed bit. It also moves the rising edge of `los` off the 175th zero. A wrong window count, mark tally or gap counter does not show until the window should end or abort. That can be up to 175 strobed bits after the opening mark, when `los` falls too early, too late or not at all. A frame counter that is off in the all-ones monitor shows as `ais` changing on the wrong bit, at most one frame later.

// File: rtl/lossig_pkg.sv
package lossig_pkg;

  // Verdict at the end of a recovery window: enough marks and no long gap.
  function automatic logic window_passes(input int unsigned ones,
                                         input int unsigned min_ones,
                                         input logic        gap_hit);
    return (!gap_hit) && (ones >= min_ones);
  endfunction

  // Verdict at the end of an all-ones frame.
  function automatic logic ais_verdict(input int unsigned zeros,
                                       input int unsigned lim);
    return zeros < lim;
  endfunction

endpackage

// File: rtl/lossig_zero_run.sv
module lossig_zero_run #(
  parameter int unsigned RUN_LIM = 175,
  parameter int unsigned RUN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             mark,
  input  logic             los,
  output logic [RUN_W-1:0] zero_run,
  output logic             set_evt
);
  localparam logic [RUN_W-1:0] SAT    = '1;
  localparam logic [RUN_W-1:0] LIM_M1 = RUN_W'(RUN_LIM - 1);

  logic [RUN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (bit_en) begin
      if (mark)            cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign zero_run = cnt_q;
  // This zero completes the threshold run.
  assign set_evt  = bit_en && !mark && !los && (cnt_q >= LIM_M1);

  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && mark |=> zero_run == '0);                           // R2
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(zero_run));                                // R9
endmodule

// File: rtl/lossig_recover.sv
module lossig_recover #(
  parameter int unsigned WIN_LEN  = 175,
  parameter int unsigned MIN_ONES = 22,
  parameter int unsigned MAX_GAP  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mark,
  input  logic los,
  output logic rec_evt,
  output logic win_active
);
  import lossig_pkg::*;

  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  localparam int unsigned GW = $clog2(MAX_GAP + 1);
  localparam logic [WW-1:0] WIN_END = WW'(WIN_LEN);
  localparam logic [GW-1:0] GAP_LIM = GW'(MAX_GAP);

  logic          active_q;
  logic [WW-1:0] win_cnt_q, ones_q, cnt_n, ones_n;
  logic [GW-1:0] gap_q, gap_n;
  logic          step, opening, gap_hit, win_end;

  always_comb begin
    step    = bit_en && los;
    opening = step && !active_q && mark;
    cnt_n   = win_cnt_q + 1'b1;
    ones_n  = ones_q + {{(WW-1){1'b0}}, mark};
    gap_n   = mark ? '0 : gap_q + 1'b1;
    gap_hit = step && active_q && (gap_n >= GAP_LIM);
    win_end = step && active_q && (cnt_n == WIN_END);
  end

  assign rec_evt    = win_end && window_passes(32'(ones_n), MIN_ONES, gap_hit);
  assign win_active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !los) begin
      active_q  <= 1'b0;
      win_cnt_q <= '0;
      ones_q    <= '0;
      gap_q     <= '0;
    end else if (opening) begin
      active_q  <= 1'b1;
      win_cnt_q <= WW'(1);
      ones_q    <= WW'(1);
      gap_q     <= '0;
    end else if (step && active_q) begin
      if (gap_hit || win_end) active_q <= 1'b0;
      win_cnt_q <= cnt_n;
      ones_q    <= ones_n;
      gap_q     <= gap_n;
    end
  end

  AST_WIN_IN_LOS: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> los);                                           // R4
  AST_OPEN_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_active) |-> $past(mark) && $past(bit_en));           // R4
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> gap_q < GAP_LIM);                               // R6
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> win_cnt_q < WIN_END);                           // R5
endmodule

// File: rtl/lossig_ais.sv
module lossig_ais #(
  parameter int unsigned WIN_LEN  = 175,
  parameter int unsigned ZERO_LIM = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mark,
  output logic ais
);
  import lossig_pkg::*;

  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

  logic [WW-1:0] cnt_q, zeros_q, zeros_n;
  logic          frame_end, ais_q;

  assign zeros_n   = zeros_q + {{(WW-1){1'b0}}, !mark};
  assign frame_end = bit_en && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      zeros_q <= '0;
      ais_q   <= 1'b0;
    end else if (bit_en) begin
      if (frame_end) begin
        cnt_q   <= '0;
        zeros_q <= '0;
        ais_q   <= ais_verdict(32'(zeros_n), ZERO_LIM);
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        zeros_q <= zeros_n;
      end
    end
  end

  assign ais = ais_q;

  AST_AIS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais) |-> $past(frame_end));                           // R8
  AST_AIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ais));                                     // R9
endmodule

// File: rtl/lossig_detector.sv
module lossig_detector #(
  parameter int unsigned DECLARE_RUN  = 175,
  parameter int unsigned WIN_LEN      = 175,
  parameter int unsigned MIN_ONES     = 22,
  parameter int unsigned MAX_GAP      = 100,
  parameter bit          AIS_EN       = 1'b1,
  parameter int unsigned AIS_ZERO_LIM = 3,
  parameter int unsigned RUN_W        = $clog2(DECLARE_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             mark,
  output logic             los,
  output logic [RUN_W-1:0] zero_run,
  output logic             ais
);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(DECLARE_RUN);

  logic los_q, set_evt, rec_evt, win_active;

  lossig_zero_run #(.RUN_LIM(DECLARE_RUN), .RUN_W(RUN_W)) u_run (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark), .los(los_q),
    .zero_run(zero_run), .set_evt(set_evt)
  );

  lossig_recover #(.WIN_LEN(WIN_LEN), .MIN_ONES(MIN_ONES), .MAX_GAP(MAX_GAP)) u_rec (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark), .los(los_q),
    .rec_evt(rec_evt), .win_active(win_active)
  );

  generate
    if (AIS_EN) begin : g_ais
      lossig_ais #(.WIN_LEN(WIN_LEN), .ZERO_LIM(AIS_ZERO_LIM)) u_ais (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark), .ais(ais)
      );
    end else begin : g_no_ais
      assign ais = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       los_q <= 1'b0;
    else if (set_evt) los_q <= 1'b1;
    else if (rec_evt) los_q <= 1'b0;
  end

  assign los = los_q;

  AST_LOS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> los);                                              // R3
  AST_LOS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> zero_run >= RUN_LIM);                           // R3
  AST_LOS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(rec_evt));                                // R5
  AST_NO_SET_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> !set_evt);                                      // R4
endmodule

// File: tb/lossig_detector_bench.sv
module lossig_detector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       mark = 1'b0;
  logic       los, ais;
  logic [7:0] zero_run;

  int    n_vec = 0, n_fail = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int   zr = 0, an = 0, az = 0;
  logic m_los = 0, m_ais = 0, win_open = 0;
  int   win[$];

  always #10 clk = ~clk;

  lossig_detector u_lossig_detector (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mark(mark),
    .los(los), .zero_run(zero_run), .ais(ais)
  );

  function automatic void m_step(input logic b);
    logic was = m_los;
    logic do_set = 0, do_clr = 0;
    if (b) zr = 0; else if (zr < 255) zr++;
    if (!was && zr >= 175) do_set = 1;
    if (was) begin
      if (!win_open) begin
        if (b) begin win_open = 1; win.delete(); win.push_back(1); end
      end else begin
        int tz = 0, sum = 0;
        win.push_back(b ? 1 : 0);
        for (int i = win.size() - 1; i >= 0 && win[i] == 0; i--) tz++;
        foreach (win[i]) sum += win[i];
        if (tz >= 100) win_open = 0;
        else if (win.size() == 175) begin
          if (sum >= 22) do_clr = 1;
          win_open = 0;
        end
      end
    end
    if (do_set) m_los = 1; else if (do_clr) m_los = 0;
    if (!m_los) win_open = 0;
    an++; if (!b) az++;
    if (an == 175) begin m_ais = (az < 3); an = 0; az = 0; end
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      zr = 0; an = 0; az = 0; m_los = 0; m_ais = 0; win_open = 0; win.delete();
    end else if (bit_en) m_step(mark);
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (los !== m_los || ais !== m_ais || zero_run !== 8'(zr)) begin
        n_fail++;
        $display("FAIL %s model: actual los=%0b ais=%0b run=%0d expected los=%0b ais=%0b run=%0d",
                 cur_req, los, ais, zero_run, m_los, m_ais, zr);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic put_bit(input logic m);
    @(posedge clk); #2; bit_en = 1'b1; mark = m;
  endtask

  task automatic flush();
    @(posedge clk); #2; bit_en = 1'b0; mark = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; bit_en = 1'b0; mark = i[0];
    end
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b0);
  endtask

  task automatic sparse_win(input int n_bits, input int last_one);
    for (int i = 0; i < n_bits; i++) put_bit((i % 8 == 0) && i <= last_one);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    chk("R1 los", los, 0); chk("R1 run", zero_run, 0); chk("R1 ais", ais, 0);
    @(posedge clk); #2; rst_n = 1'b1;

    cur_req = "R2";
    for (int i = 0; i < 500; i++) begin
      put_bit(($urandom % 5) != 0);
      if (i % 7 == 0) idle(2);
    end
    put_bit(1); zeros(5); flush();
    chk("R2 run count", zero_run, 5);

    cur_req = "R9";
    idle(10); @(negedge clk);
    chk("R9 run held", zero_run, 5); chk("R9 los held", los, 0);

    cur_req = "R3";
    put_bit(1); zeros(174); flush();
    chk("R3 los after 174", los, 0); chk("R3 run 174", zero_run, 174);
    put_bit(0); flush();
    chk("R3 los after 175", los, 1);

    cur_req = "R4";
    zeros(100); flush();
    chk("R4 los held by zeros", los, 1); chk("R2 saturate", zero_run, 255);

    cur_req = "R5";
    sparse_win(174, 168); flush();
    chk("R5 los before end", los, 1);
    put_bit(0); flush();
    chk("R5 los cleared", los, 0);

    cur_req = "R6";
    put_bit(1); zeros(175); flush();
    chk("R6 relatch", los, 1);
    put_bit(1); zeros(99);
    for (int i = 0; i < 75; i++) put_bit(1);
    flush();
    chk("R6 gap 99 passes", los, 0);
    put_bit(1); zeros(175);
    put_bit(1); zeros(100);
    for (int i = 0; i < 74; i++) put_bit(1);
    flush();
    chk("R6 gap 100 aborts", los, 1);
    for (int i = 0; i < 100; i++) put_bit(1);
    flush();
    chk("R6 reopened early", los, 1);
    put_bit(1); flush();
    chk("R6 reopened window clears", los, 0);

    cur_req = "R7";
    put_bit(1); zeros(175);
    sparse_win(175, 160); flush();
    chk("R7 21 marks", los, 1);
    sparse_win(175, 168); flush();
    chk("R7 next window 22 marks", los, 0);

    cur_req = "R8";
    for (int i = 0; i < 400; i++) put_bit(1);
    flush();
    chk("R8 all ones", ais, 1);
    for (int i = 0; i < 400; i++) put_bit(i % 100 != 0);
    flush();
    chk("R8 two zeros per frame", ais, 1);
    for (int i = 0; i < 400; i++) put_bit(i % 50 != 0);
    flush();
    chk("R8 zeros every 50", ais, 0);

    cur_req = "R9";
    for (int i = 0; i < 300; i++) begin
      put_bit(($urandom % 3) == 0);
      idle(1);
    end
    flush();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL %s watchdog: actual hung expected finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule